// File: doc/BRIEF.md
# Overlapped Loop Iteration Sequencer

This block sits behind the decoder of a vector-style loop construct. When a loop-start instruction is accepted, it latches the instruction's fields: the index register, the power-of-two step, the intermediate-register mask, the register group, the bank select and the preamble flag. It also latches a trip count. It then emits one iteration per handshake on a valid/ready stream to the downstream issue stage. Each issued iteration carries its ordinal number and its index value. While the loop runs, the block also drives a 32-bit classification word for each register bank. A set bit in that word marks the register as a per-iteration forwarding node. A clear bit marks it as a read-only constant for the whole loop.

When the preamble flag is clear, iterations go out on back-to-back cycles. When it is set, each iteration's serial preamble must report completion on `pre_end` before that iteration's body may issue. The number of issued but unretired iterations is capped. Retirements come back on `it_retire`. A one-cycle `done` pulse follows the last issue.

Top module: `lps_loop_seq`

## Requirements
- R1: After reset, `it_valid`, `busy` and `done` are 0 and both classification words are zero; the classification words are also zero whenever `busy` is 0.
- R2: While busy, the bank chosen by `cfg_fp_bank` (0 = integer word `int_cls`, 1 = floating-point word `fp_cls`) shows `cfg_node_mask` in bits `cfg_group*8+7` down to `cfg_group*8`, plus bit `cfg_group*8+cfg_idx_reg` set; every other bit of both words is 0.
- R3: The iteration numbered n (counting from 0) carries `it_index` equal to n shifted left by `cfg_step_log2`, truncated to IDX_W bits, so the first index is 0.
- R4: With no preamble, `it_ready` held at 1 and room below the in-flight limit, a loop of T iterations issues on T consecutive cycles, the first being the cycle after `start` is accepted.
- R5: A loop with trip count T > 0 issues exactly T iterations, numbered 0 to T-1 in order.
- R6: `done` is 1 for exactly the one cycle after the last iteration is accepted; in that cycle `busy` is 0. A start with trip count 0 issues nothing and gives `done` in the cycle after the start.
- R7: While `it_valid` is 1 and `it_ready` is 0, the next cycle keeps `it_valid` at 1 with `it_num` and `it_index` unchanged.
- R8: Issued-minus-retired iterations never exceed MAX_INFL (default 8); `it_valid` is 0 when that count equals MAX_INFL. A retire pulse with none in flight has no effect.
- R9: With the preamble flag set, an iteration is offered only in cycles after a `pre_end` pulse that followed the previous accepted iteration (or the start); each accepted iteration consumes that grant.
- R10: A `start` pulse while `busy` is 1 is ignored: numbering, indices, classification and the count of issued iterations are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Loop-start instruction present |
| cfg_idx_reg | input | 3 | Index register within the chosen group |
| cfg_step_log2 | input | 3 | Step exponent k, step = 2^k |
| cfg_node_mask | input | 8 | Intermediate-register mask for the chosen group |
| cfg_group | input | 2 | Eight-register group within the 32-register bank |
| cfg_fp_bank | input | 1 | 0 = integer bank, 1 = floating-point bank |
| cfg_pre_en | input | 1 | Loop has a serial preamble |
| trip_count | input | CNT_W | Iterations to issue |
| pre_end | input | 1 | Current iteration's preamble has finished |
| it_ready | input | 1 | Downstream accepts an iteration |
| it_retire | input | 1 | One in-flight iteration completed |
| it_valid | output | 1 | Iteration offered |
| it_num | output | CNT_W | Iteration number |
| it_index | output | IDX_W | Per-iteration index value |
| int_cls | output | 32 | Integer-bank forwarding-node flags |
| fp_cls | output | 32 | Floating-point-bank forwarding-node flags |
| busy | output | 1 | Loop in progress |
| done | output | 1 | Last iteration issued (one-cycle pulse) |

## Verification
The checker watches several properties on every cycle. It checks the hold of an offered iteration under back-pressure and the step of one in the iteration number after each acceptance. It also checks the in-flight ceiling against its own count of issues and retirements, and that the classification words and the offer are silent whenever the block is idle or signalling completion. Other behaviours depend on the configuration of the loop, so only the bench's scenarios can show them. These are the exact classification bit pattern for each group and bank, the index arithmetic for each step exponent, and the trip-count total. The same holds for consecutive issue, the preamble gating, and the rejection of a second start while a loop runs.

// File: rtl/lps_pkg.sv
// Package: shared types and instruction-format constants for the loop
// sequencer. Assumes a 32-register bank split into four 8-register groups.
package lps_pkg;

    localparam int GROUP_REGS = 8;
    localparam int BANK_REGS  = 32;
    localparam int NUM_BANKS  = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [2:0]            idx_reg;
        logic [2:0]            step_log2;
        logic [GROUP_REGS-1:0] node_mask;
        logic [1:0]            group;
        logic                  fp_bank;
        logic                  pre_en;
    } loop_cfg_t;

endpackage

// File: rtl/lps_inflight.sv
// Module: counts iterations issued but not yet retired and flags when the
// ceiling is reached. Assumes inc fires only when full is 0; a decrement
// request at zero is dropped.
module lps_inflight #(
    parameter int MAX_INFL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full
);
    localparam int CW = $clog2(MAX_INFL + 1);

    logic [CW-1:0] cnt;
    logic          dec_eff;

    // Drop a retire when nothing is outstanding.
    assign dec_eff = dec && (cnt != '0);

    // Track the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && !dec_eff) begin
            cnt <= cnt + CW'(1);
        end else if (!inc && dec_eff) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Ceiling reached.
    assign full = (cnt == CW'(MAX_INFL));

endmodule

// File: rtl/lps_classify.sv
// Module: builds one 32-bit forwarding-node word per bank from the latched
// loop configuration. Assumes cfg is stable while active is 1; the words
// read zero when active is 0.
module lps_classify
    import lps_pkg::*;
(
    input  loop_cfg_t                         cfg,
    input  logic                              active,
    output logic [NUM_BANKS-1:0][BANK_REGS-1:0] cls
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Place the mask in the chosen group and add the index register.
        always_comb begin
            cls[b] = '0;
            if (active && (cfg.fp_bank == b[0])) begin
                cls[b][{cfg.group, 3'b000} +: GROUP_REGS] = cfg.node_mask;
                cls[b][{cfg.group, cfg.idx_reg}]          = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lps_issue_ctl.sv
// Module: loop state machine. Counts down the trip count, numbers the
// iterations, gates each issue on the preamble grant and on in-flight room,
// and pulses done after the last acceptance. Assumes pre_en is the latched
// preamble flag of the running loop.
module lps_issue_ctl
    import lps_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] trip_count,
    input  logic             pre_en,
    input  logic             pre_end,
    input  logic             room,
    input  logic             it_ready,
    output logic             accept,
    output logic             it_valid,
    output logic             fire,
    output logic [CNT_W-1:0] iter_num,
    output logic             busy,
    output logic             done
);
    seq_state_t       state;
    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] num;
    logic             pre_ok;
    logic             done_q;

    // A new loop is taken only when idle.
    assign accept   = start && (state == ST_IDLE);
    // Offer an iteration when running, with room and any preamble done.
    assign it_valid = (state == ST_RUN) && room && (!pre_en || pre_ok);
    assign fire     = it_valid && it_ready;

    // Sequence state, counters, preamble grant and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            num       <= '0;
            pre_ok    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                num    <= '0;
                pre_ok <= 1'b0;
                if (trip_count == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state     <= ST_RUN;
                    remaining <= trip_count;
                end
            end else if (state == ST_RUN) begin
                if (fire) begin
                    num       <= num + CNT_W'(1);
                    remaining <= remaining - CNT_W'(1);
                    pre_ok    <= 1'b0;
                    if (remaining == CNT_W'(1)) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end else if (pre_end && pre_en) begin
                    pre_ok <= 1'b1;
                end
            end
        end
    end

    assign iter_num = num;
    assign busy     = (state == ST_RUN);
    assign done     = done_q;

endmodule

// File: rtl/lps_loop_seq.sv
// Module: top of the loop iteration sequencer. Latches the loop-start fields
// on acceptance, forms the per-iteration index as number << step, and exposes
// the register classification words. Assumes downstream follows valid/ready.
module lps_loop_seq
    import lps_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int IDX_W    = 16,
    parameter int MAX_INFL = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           cfg_idx_reg,
    input  logic [2:0]           cfg_step_log2,
    input  logic [7:0]           cfg_node_mask,
    input  logic [1:0]           cfg_group,
    input  logic                 cfg_fp_bank,
    input  logic                 cfg_pre_en,
    input  logic [CNT_W-1:0]     trip_count,
    input  logic                 pre_end,
    input  logic                 it_ready,
    input  logic                 it_retire,
    output logic                 it_valid,
    output logic [CNT_W-1:0]     it_num,
    output logic [IDX_W-1:0]     it_index,
    output logic [BANK_REGS-1:0] int_cls,
    output logic [BANK_REGS-1:0] fp_cls,
    output logic                 busy,
    output logic                 done
);
    loop_cfg_t                          cfg_q;
    logic                               accept;
    logic                               fire;
    logic                               full;
    logic [NUM_BANKS-1:0][BANK_REGS-1:0] cls;

    // Capture the loop-start fields when a new loop is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= '{idx_reg:   cfg_idx_reg,
                       step_log2: cfg_step_log2,
                       node_mask: cfg_node_mask,
                       group:     cfg_group,
                       fp_bank:   cfg_fp_bank,
                       pre_en:    cfg_pre_en};
        end
    end

    lps_issue_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .trip_count (trip_count),
        .pre_en     (cfg_q.pre_en),
        .pre_end    (pre_end),
        .room       (!full),
        .it_ready   (it_ready),
        .accept     (accept),
        .it_valid   (it_valid),
        .fire       (fire),
        .iter_num   (it_num),
        .busy       (busy),
        .done       (done)
    );

    lps_inflight #(.MAX_INFL(MAX_INFL)) u_infl (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fire),
        .dec   (it_retire),
        .full  (full)
    );

    lps_classify u_cls (
        .cfg    (cfg_q),
        .active (busy),
        .cls    (cls)
    );

    // Index is the iteration number scaled by the power-of-two step.
    assign it_index = IDX_W'(it_num) << cfg_q.step_log2;
    assign int_cls  = cls[0];
    assign fp_cls   = cls[1];

endmodule

// File: rtl/lps_loop_seq_chk.sv
// Module: protocol checker for the loop sequencer, bound to the top. Keeps its
// own outstanding count from the handshake and retire pulses.
module lps_loop_seq_chk #(
    parameter int CNT_W    = 8,
    parameter int IDX_W    = 16,
    parameter int MAX_INFL = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             it_ready,
    input logic             it_retire,
    input logic             it_valid,
    input logic [CNT_W-1:0] it_num,
    input logic [IDX_W-1:0] it_index,
    input logic [31:0]      int_cls,
    input logic [31:0]      fp_cls,
    input logic             busy,
    input logic             done
);
    logic [15:0] outst;
    logic        acc;

    assign acc = it_valid && it_ready;

    // Independent outstanding-iteration count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst <= '0;
        end else begin
            outst <= outst + {15'd0, acc} - {15'd0, (it_retire && outst != '0)};
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!it_valid && int_cls == '0 && fp_cls == '0));

    p_num_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (it_num == $past(it_num) + CNT_W'(1)));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !it_valid));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (it_valid && !it_ready) |=> (it_valid && $stable(it_num) && $stable(it_index)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= 16'(MAX_INFL));

    p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (outst == 16'(MAX_INFL)) |-> !it_valid);

endmodule

bind lps_loop_seq lps_loop_seq_chk #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .MAX_INFL(MAX_INFL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .it_ready  (it_ready),
    .it_retire (it_retire),
    .it_valid  (it_valid),
    .it_num    (it_num),
    .it_index  (it_index),
    .int_cls   (int_cls),
    .fp_cls    (fp_cls),
    .busy      (busy),
    .done      (done)
);

// File: tb/lps_loop_seq_bench.sv
module lps_loop_seq_bench;
    localparam int CNT_W    = 8;
    localparam int IDX_W    = 16;
    localparam int MAX_INFL = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       cfg_idx_reg = '0;
    logic [2:0]       cfg_step_log2 = '0;
    logic [7:0]       cfg_node_mask = '0;
    logic [1:0]       cfg_group = '0;
    logic             cfg_fp_bank = 1'b0;
    logic             cfg_pre_en = 1'b0;
    logic [CNT_W-1:0] trip_count = '0;
    logic             pre_end = 1'b0;
    logic             it_ready = 1'b0;
    logic             it_retire = 1'b0;
    logic             it_valid;
    logic [CNT_W-1:0] it_num;
    logic [IDX_W-1:0] it_index;
    logic [31:0]      int_cls;
    logic [31:0]      fp_cls;
    logic             busy;
    logic             done;

    int checks = 0;
    int fails  = 0;
    int outst  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lps_loop_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W), .MAX_INFL(MAX_INFL)) u_lps_loop_seq (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [7:0] m, input logic [1:0] g, input logic [2:0] i);
        logic [31:0] w = '0;
        w[g*8 +: 8] = m;
        w[g*8 + i]  = 1'b1;
        return w;
    endfunction

    // Run one loop; returns number of cycles spent in the issue phase.
    task automatic run_loop(input int trip, input logic [2:0] idx, input logic [2:0] stp,
                            input logic [7:0] msk, input logic [1:0] grp, input bit fpb,
                            input bit pre, input int rdy_pct, input int ret_pct,
                            input bit junk_start, output int cyc);
        int rem = trip, n = 0;
        bit granted = 0;
        logic [31:0] ew = exp_word(msk, grp, idx);
        cyc = 0;
        @(negedge clk);
        start = 1; cfg_idx_reg = idx; cfg_step_log2 = stp; cfg_node_mask = msk;
        cfg_group = grp; cfg_fp_bank = fpb; cfg_pre_en = pre; trip_count = CNT_W'(trip);
        it_ready = 0; it_retire = 0; pre_end = 0;
        @(posedge clk);
        if (trip == 0) begin
            @(negedge clk); start = 0; #1;
            chk(done && !busy && !it_valid, "R6 zero trip", {done, busy, it_valid}, 3'b100);
            return;
        end
        while (rem > 0) begin
            bit ev, fire, ret;
            @(negedge clk);
            start = junk_start && ($urandom_range(0, 3) == 0);
            cfg_node_mask = 8'($urandom); cfg_group = 2'($urandom); cfg_fp_bank = 1'($urandom);
            cfg_idx_reg = 3'($urandom); cfg_step_log2 = 3'($urandom); trip_count = 8'($urandom);
            it_ready  = ($urandom_range(1, 100) <= rdy_pct);
            ret = (outst > 0) && ($urandom_range(1, 100) <= ret_pct);
            it_retire = ret;
            pre_end = pre && !granted && ($urandom_range(0, 2) == 0);
            #1;
            ev = (outst < MAX_INFL) && (!pre || granted);
            chk(it_valid == ev, pre ? "R9 preamble gate" : "R8 in-flight gate", it_valid, ev);
            chk(busy && (fpb ? (fp_cls == ew && int_cls == 0) : (int_cls == ew && fp_cls == 0)),
                junk_start ? "R10 cls kept" : "R2 classification", fpb ? fp_cls : int_cls, ew);
            fire = it_valid && it_ready;
            if (fire) begin
                logic [IDX_W-1:0] ei = IDX_W'(n) << stp;
                chk(it_num == CNT_W'(n), "R5 iteration number", it_num, n);
                chk(it_index == ei, "R3 index", it_index, ei);
                n++; rem--; granted = 0; outst++;
            end else if (pre_end) begin
                granted = 1;
            end
            if (ret) outst--;
            cyc++;
        end
        @(negedge clk);
        start = 0; it_retire = 0; pre_end = 0; #1;
        chk(done && !busy, "R6 done pulse", {done, busy}, 2'b10);
        chk(n == trip, "R5 count", n, trip);
        @(negedge clk); #1;
        chk(!done, "R6 single pulse", done, 0);
    endtask

    initial begin
        int cyc;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(!it_valid && !busy && !done && int_cls == 0 && fp_cls == 0, "R1 reset state",
            {it_valid, busy, done}, 0);
        rst_n = 1;
        // R4: back-to-back issue
        run_loop(6, 3'd2, 3'd1, 8'h0C, 2'd1, 0, 0, 100, 100, 0, cyc);
        chk(cyc == 6, "R4 consecutive cycles", cyc, 6);
        // R6: zero trip
        run_loop(0, 3'd0, 3'd0, 8'h00, 2'd0, 0, 0, 100, 100, 0, cyc);
        // R8: ceiling with slow retire
        run_loop(20, 3'd7, 3'd3, 8'h81, 2'd3, 1, 0, 100, 10, 0, cyc);
        // R7: back-pressure
        run_loop(10, 3'd0, 3'd7, 8'hF0, 2'd0, 1, 0, 30, 60, 0, cyc);
        // R9: preamble
        run_loop(9, 3'd5, 3'd2, 8'h00, 2'd2, 0, 1, 80, 70, 0, cyc);
        // R10: start pulses while busy
        run_loop(12, 3'd1, 3'd4, 8'h5A, 2'd1, 1, 0, 70, 50, 1, cyc);
        // Random mix
        for (int k = 0; k < 40; k++) begin
            run_loop($urandom_range(0, 30), 3'($urandom), 3'($urandom), 8'($urandom),
                     2'($urandom), 1'($urandom), 1'($urandom), $urandom_range(20, 100),
                     $urandom_range(10, 100), 1'($urandom), cyc);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule